// File: doc/BRIEF.md
# Sampling converter parallel-bus host controller

This block sits between user logic and an external 12-bit sampling analog-to-digital converter. The converter has a tri-state parallel result bus, an active-low chip select, a sample/hold strobe, a read strobe, an output enable and a two-way input select line. The converter reports progress on an end-of-conversion line, which is low while a conversion runs, and on an active-low interrupt line. User logic asks for a conversion on a valid/ready request port, naming one of two analog inputs. The controller sequences the converter pins, waits for completion, reads the result over the bus and hands back the 12-bit value, tagged with its channel, on a valid/ready result port.

Two completion schemes are supported, chosen per request. In interrupt mode the controller waits for the interrupt line to fall, then opens a read window that also clears the interrupt. In held-read mode the read strobe stays low at all times, so the converter never raises its interrupt, and completion is taken from end-of-conversion returning high. Both converter status lines pass through two-flop synchronizers. A watchdog on each conversion ends the transaction with a one-cycle error pulse if completion never comes.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, adc_cs_n=1, adc_sh_n=1, adc_rd_n=1, adc_oe=0, res_valid=0, err_timeout=0 and req_ready=1.
- R2: adc_sel carries the accepted req_chan (0 selects analog input 1, 1 selects input 2) when the sample pulse starts, and does not change while adc_cs_n stays low.
- R3: Each accepted request gives exactly one adc_sh_n low pulse, one clock cycle long, and only while adc_cs_n is low.
- R4: In interrupt mode (req_rdmode=0 at acceptance), the controller drives adc_rd_n low and adc_oe high only after the synchronized adc_int_n is seen low, holds them for SETTLE_CYCLES+1 cycles, and releases them after capture. The read therefore clears the interrupt (adc_int_n high afterwards), and adc_rd_n is high while idle.
- R5: In held-read mode (req_rdmode=1 at acceptance), adc_rd_n is low in every cycle, idle included, until a request in interrupt mode is accepted. Completion is taken from adc_eoc returning high after it was seen low, and the converter's interrupt never falls.
- R6: res_data equals the value on adc_db during the capture cycle. Once res_valid is set, res_valid, res_data and res_chan hold until res_ready is high.
- R7: adc_oe is never high while adc_cs_n is high.
- R8: If completion is not seen within TIMEOUT_CYCLES cycles after the sample pulse, err_timeout pulses high for one cycle, no result is produced, adc_cs_n returns high, and req_ready returns high.
- R9: req_ready is low from acceptance until the result has been taken, and it is high only while adc_cs_n is high.
- R10: res_chan is the channel that was on adc_sel when end-of-conversion fell. Changes to req_chan after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Controller can accept a request |
| req_chan | input | 1 | Requested analog input (0 = input 1, 1 = input 2) |
| req_rdmode | input | 1 | 1 = held-read mode, 0 = interrupt mode |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_data | output | 12 | Conversion result |
| res_chan | output | 1 | Channel the result was taken from |
| err_timeout | output | 1 | One-cycle pulse when a conversion times out |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sh_n | output | 1 | Sample/hold strobe, active-low pulse |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_oe | output | 1 | Output enable, active high |
| adc_sel | output | 1 | Analog input select |
| adc_eoc | input | 1 | End-of-conversion, low while converting |
| adc_int_n | input | 1 | Converter interrupt, active low |
| adc_db | input | 12 | Converter result bus (high impedance when not enabled) |

## Verification
The hardest case to reach from the ports is a timeout: the converter must take the sample strobe and then never finish. The bench's converter model has a mute switch that makes it ignore the strobe, so the controller sits in its wait state until the watchdog expires. Another hard case is showing that held-read mode keeps the interrupt quiet. The model raises its interrupt only when read is not asserted at the end of a conversion, and the bench counts every fall of that line during held-read runs. A third is proving that the channel tag comes from the select line and not from the request input. For this, the bench flips req_chan right after acceptance, and the model encodes the channel it latched into the result value.

// File: rtl/adc_bus_ctrl_pkg.sv
package adc_bus_ctrl_pkg;

    localparam int ADC_RES_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SAMPLE,
        ST_WAIT_EOC,
        ST_WAIT_DONE,
        ST_READ,
        ST_CAPTURE,
        ST_RELEASE
    } ctrl_state_t;

    typedef struct packed {
        logic                 chan;
        logic [ADC_RES_W-1:0] data;
    } conv_word_t;

    function automatic logic bus_phase(input ctrl_state_t s);
        return (s == ST_READ) || (s == ST_CAPTURE);
    endfunction

    function automatic logic wait_phase(input ctrl_state_t s);
        return (s == ST_WAIT_EOC) || (s == ST_WAIT_DONE);
    endfunction

endpackage

// File: rtl/adc_bus_sync.sv
module adc_bus_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/adc_bus_dcnt.sv
module adc_bus_dcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_bus_outreg.sv
module adc_bus_outreg
    import adc_bus_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_valid,
    input  conv_word_t cap_word,
    output logic       out_valid,
    input  logic       out_ready,
    output conv_word_t out_word
);
    logic       valid_q;
    conv_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (cap_valid) begin
            valid_q <= 1'b1;
            word_q  <= cap_word;
        end else if (valid_q && out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R6
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_ctrl_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256,
    parameter int SETTLE_CYCLES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_chan,
    input  logic                 req_rdmode,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [ADC_RES_W-1:0] res_data,
    output logic                 res_chan,
    output logic                 err_timeout,
    output logic                 adc_cs_n,
    output logic                 adc_sh_n,
    output logic                 adc_rd_n,
    output logic                 adc_oe,
    output logic                 adc_sel,
    input  logic                 adc_eoc,
    input  logic                 adc_int_n,
    input  logic [ADC_RES_W-1:0] adc_db
);
    localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam int SW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [TW-1:0] TMO_LOAD    = TW'(TIMEOUT_CYCLES - 1);
    localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES - 1);

    ctrl_state_t state_q, state_d;
    logic        chan_q, tag_q, mode_q;
    logic        err_q;
    logic        eoc_s, int_n_s;
    logic        accept, done_seen, expire;
    logic        tmo_zero, settle_zero;
    logic        cap_valid;
    conv_word_t  cap_word, out_word;

    // status lines come from another clock domain
    adc_bus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({adc_eoc, adc_int_n}),
        .sync_out ({eoc_s, int_n_s})
    );

    assign req_ready = (state_q == ST_IDLE) && !res_valid;
    assign accept    = req_valid && req_ready;
    assign done_seen = mode_q ? eoc_s : !int_n_s;

    always_comb begin
        expire = 1'b0;
        if (state_q == ST_WAIT_EOC)  expire = eoc_s && tmo_zero;
        if (state_q == ST_WAIT_DONE) expire = !done_seen && tmo_zero;
    end

    adc_bus_dcnt #(.W(TW)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_SAMPLE),
        .load_val (TMO_LOAD),
        .dec      (wait_phase(state_q)),
        .zero     (tmo_zero)
    );

    adc_bus_dcnt #(.W(SW)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     ((state_q == ST_WAIT_DONE) && done_seen),
        .load_val (SETTLE_LOAD),
        .dec      (state_q == ST_READ),
        .zero     (settle_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_SETUP;
            ST_SETUP:     state_d = ST_SAMPLE;
            ST_SAMPLE:    state_d = ST_WAIT_EOC;
            ST_WAIT_EOC: begin
                if (!eoc_s)        state_d = ST_WAIT_DONE;
                else if (tmo_zero) state_d = ST_RELEASE;
            end
            ST_WAIT_DONE: begin
                if (done_seen)     state_d = ST_READ;
                else if (tmo_zero) state_d = ST_RELEASE;
            end
            ST_READ:      if (settle_zero) state_d = ST_CAPTURE;
            ST_CAPTURE:   state_d = ST_RELEASE;
            ST_RELEASE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chan_q  <= 1'b0;
            tag_q   <= 1'b0;
            mode_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= expire;
            if (accept) begin
                chan_q <= req_chan;
                mode_q <= req_rdmode;
            end
            // channel in force when the conversion began
            if ((state_q == ST_WAIT_EOC) && !eoc_s) tag_q <= chan_q;
        end
    end

    assign adc_cs_n    = (state_q == ST_IDLE) || (state_q == ST_RELEASE);
    assign adc_sh_n    = (state_q != ST_SAMPLE);
    assign adc_oe      = bus_phase(state_q);
    assign adc_rd_n    = !(mode_q || bus_phase(state_q));
    assign adc_sel     = chan_q;
    assign err_timeout = err_q;

    assign cap_valid     = (state_q == ST_CAPTURE);
    assign cap_word.chan = tag_q;
    assign cap_word.data = adc_db;

    adc_bus_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .cap_word  (cap_word),
        .out_valid (res_valid),
        .out_ready (res_ready),
        .out_word  (out_word)
    );

    assign res_data = out_word.data;
    assign res_chan = out_word.chan;

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_sel)); // R2
    AST_SH_IN_CS: assert property (@(posedge clk) disable iff (rst)
        !adc_sh_n |-> !adc_cs_n); // R3
    AST_SH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !adc_sh_n |=> adc_sh_n); // R3
    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !adc_rd_n) |-> (adc_oe && !adc_cs_n)); // R4
    AST_HOLD_RD: assert property (@(posedge clk) disable iff (rst)
        (mode_q && $past(mode_q) && adc_cs_n) |-> !adc_rd_n); // R5
    AST_OE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        adc_oe |-> !adc_cs_n); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_timeout |=> (!err_timeout && req_ready)); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (adc_cs_n && !res_valid)); // R9
endmodule

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;
    localparam int TMO = 256;
    localparam int CONV_CYC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_chan = 1'b0, req_rdmode = 1'b0, res_ready = 1'b0;
    logic        req_ready, res_valid, res_chan, err_timeout;
    logic [11:0] res_data;
    logic        adc_cs_n, adc_sh_n, adc_rd_n, adc_oe, adc_sel;
    wire  [11:0] adc_db;

    // behavioural converter model
    logic        m_mute = 1'b0;
    logic        m_eoc, m_int_n, m_busy, m_chan, sh_prev, int_prev;
    logic [11:0] m_latch;
    logic [7:0]  m_seq;
    int          m_cnt;
    int          sh_cnt = 0, oe_bad = 0, int_falls = 0, err_cnt = 0;
    logic        sel_at_sh;

    always @(posedge clk) begin
        if (rst) begin
            m_eoc <= 1'b1; m_int_n <= 1'b1; m_busy <= 1'b0; m_chan <= 1'b0;
            sh_prev <= 1'b1; m_latch <= '0; m_seq <= '0; m_cnt <= 0;
        end else begin
            sh_prev <= adc_sh_n;
            if (!adc_cs_n && !adc_rd_n) m_int_n <= 1'b1;
            if (!m_busy && !m_mute && sh_prev && !adc_sh_n && !adc_cs_n) begin
                m_busy <= 1'b1; m_cnt <= 0;
            end else if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == 1) begin
                    m_eoc <= 1'b0; m_chan <= adc_sel;
                end
                if (m_cnt == CONV_CYC) begin
                    m_eoc   <= 1'b1; m_busy <= 1'b0;
                    m_latch <= (m_chan ? 12'hA00 : 12'h300) + {4'h0, m_seq};
                    m_seq   <= m_seq + 8'd1;
                    if (!(!adc_cs_n && !adc_rd_n)) m_int_n <= 1'b0;
                end
            end
        end
    end

    assign adc_db = (!adc_cs_n && !adc_rd_n && adc_oe) ? m_latch : 12'hzzz;

    // port monitors
    always @(posedge clk) begin
        int_prev <= m_int_n;
        if (!rst) begin
            if (!adc_sh_n) begin sh_cnt <= sh_cnt + 1; sel_at_sh <= adc_sel; end
            if (adc_oe && adc_cs_n) oe_bad <= oe_bad + 1;
            if (int_prev && !m_int_n) int_falls <= int_falls + 1;
            if (err_timeout) err_cnt <= err_cnt + 1;
        end
    end

    adc_bus_ctrl #(.TIMEOUT_CYCLES(TMO), .SETTLE_CYCLES(2)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .req_rdmode(req_rdmode),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan), .err_timeout(err_timeout),
        .adc_cs_n(adc_cs_n), .adc_sh_n(adc_sh_n), .adc_rd_n(adc_rd_n),
        .adc_oe(adc_oe), .adc_sel(adc_sel), .adc_eoc(m_eoc),
        .adc_int_n(m_int_n), .adc_db(adc_db)
    );

    int n_chk = 0, n_bad = 0;
    int exp_seq = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic send_req(input logic ch, input logic md);
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_rdmode = md;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_chan  = ~ch;   // R10: later changes must not matter
    endtask

    task automatic t_reset;
        check(adc_cs_n && adc_sh_n && adc_rd_n && !adc_oe, "R1 pins",
              {adc_cs_n, adc_sh_n, adc_rd_n, adc_oe}, 4'b1110);
        check(!res_valid && !err_timeout && req_ready, "R1 handshake",
              {res_valid, err_timeout, req_ready}, 3'b001);
    endtask

    task automatic t_convert(input logic ch, input logic md, input int hold);
        int sh0 = sh_cnt;
        int if0 = int_falls;
        int w = 0;
        logic [11:0] exp_d = (ch ? 12'hA00 : 12'h300) + 12'(exp_seq);
        logic [11:0] d0;
        send_req(ch, md);
        check(!req_ready, "R9 busy", req_ready, 0);
        while (!res_valid && w < 400) begin @(negedge clk); w++; end
        check(res_valid, "R4/R5 completion", res_valid, 1);
        exp_seq++;
        check(res_data == exp_d, "R6 data", res_data, exp_d);
        check(res_chan == ch, "R10 channel tag", res_chan, ch);
        check(sel_at_sh == ch, "R2 select at sample", sel_at_sh, ch);
        check(sh_cnt == sh0 + 1, "R3 one sample pulse", sh_cnt - sh0, 1);
        d0 = res_data;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(res_valid && res_data == d0 && !req_ready, "R6/R9 hold", res_data, d0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!res_valid && req_ready, "R9 released", {res_valid, req_ready}, 2'b01);
        if (md) begin
            check(!adc_rd_n, "R5 read held low in idle", adc_rd_n, 0);
            check(int_falls == if0, "R5 interrupt quiet", int_falls - if0, 0);
        end else begin
            check(adc_rd_n && !adc_oe, "R4 read released", {adc_rd_n, adc_oe}, 2'b10);
            check(m_int_n && int_falls == if0 + 1, "R4 interrupt cleared",
                  int_falls - if0, 1);
        end
    endtask

    task automatic t_timeout;
        int e0 = err_cnt;
        int w = 0;
        logic saw_res = 1'b0;
        m_mute = 1'b1;
        send_req(1'b0, 1'b0);
        while (err_cnt == e0 && w < TMO + 100) begin
            @(negedge clk); w++;
            if (res_valid) saw_res = 1'b1;
        end
        check(err_cnt == e0 + 1, "R8 error pulse", err_cnt - e0, 1);
        check(w > TMO - 10, "R8 waited full window", w, TMO);
        repeat (3) @(negedge clk);
        check(!saw_res && !res_valid, "R8 no result", res_valid, 0);
        check(req_ready && adc_cs_n && err_cnt == e0 + 1, "R8 back to idle",
              {req_ready, adc_cs_n}, 2'b11);
        m_mute = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_convert(1'b0, 1'b0, 0);
        t_convert(1'b1, 1'b0, 3);
        t_convert(1'b1, 1'b1, 2);
        t_convert(1'b0, 1'b1, 0);
        t_convert(1'b0, 1'b0, 1);
        t_timeout();
        t_convert(1'b1, 1'b0, 0);
        check(oe_bad == 0, "R7 enable only with select", oe_bad, 0);
        finish_run();
    end
endmodule